// File: doc/BRIEF.md
# SIMD Lane Shift-Insert Unit

This datapath block runs the merging left-shift step of a vector unit. A source vector and a destination vector are cut into lanes of equal width: 8, 16, 32 or 64 bits. In every lane the source value is moved left by an unsigned amount. Bits that pass the top of the lane are dropped. The moved value is then written over the destination lane from the shift point upward, and the destination bits below that point stay as they were. Lane width and shift count are not given separately: both come from one packed 7-bit field.

An operand-width input picks one of two forms. The full form works on the whole vector. The half form works only on the low half, and the upper half of the destination passes through unchanged. A field whose size part has no set bit is illegal. The block flags it and returns the destination untouched. The result is registered and appears with its valid flag one clock after the input strobe. No condition or status flags exist.

Top module: `lane_shift_insert`

## Requirements
- R1: When field bit 6 is 1, lanes are 64 bits wide and the shift count is field bits 5:0.
- R2: When field bit 6 is 0, the highest set bit among field bits 5, 4 and 3 picks the lane width: bit 5 gives 32 bits with shift bits 4:0, bit 4 gives 16 bits with shift bits 3:0, and bit 3 gives 8 bits with shift bits 2:0.
- R3: Source bits shifted past the top of a lane are discarded and never reach the next lane.
- R4: Each result lane equals (dest AND NOT mask) OR (source << shift), where mask is all ones of the lane width shifted left by the shift count. Destination bits below the shift count are kept.
- R5: A shift count of zero copies the source lane whole into the result.
- R6: When `wide_sel` is 0, only the low half of the vector is processed, and the upper half of `out_vec` equals the upper half of `dst_vec`.
- R7: When field bit 6 is 0 and field bits 5:3 are all 0, `out_illegal` is 1 and `out_vec` equals `dst_vec`. For any other field it is 0.
- R8: `out_valid` equals `in_valid` one clock earlier. `out_vec` and `out_illegal` update only on a clock where `in_valid` is 1 and hold otherwise.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `out_illegal` and `out_vec` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | VEC_W | Source vector whose lanes are shifted |
| dst_vec | input | VEC_W | Destination vector that is merged into |
| imm_field | input | 7 | Packed size bit and 6-bit immediate |
| wide_sel | input | 1 | 1 = full-width form, 0 = half-width form |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_vec | output | VEC_W | Merged result |
| out_illegal | output | 1 | Field had no usable size bit |

## Verification
The checker assumes that `imm_field`, `wide_sel` and both vectors are steady across the clock edge where `in_valid` is sampled, so that `$past` of the inputs describes the operation that was taken. It also assumes that reset is held for at least one edge before any strobe. The bench changes inputs only on falling edges and raises `in_valid` for one cycle per operation, which keeps both assumptions true. The bench then compares each result with a bit-by-bit model of the lane rules, covering every lane width, edge shift counts, both operand forms and the illegal fields.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
   localparam int FIELD_W   = 7;
   localparam int SHAMT_W   = 6;
   localparam int NUM_SIZES = 4;
   localparam int MIN_LANE  = 8;

   typedef enum logic [1:0] {
      LANE_8  = 2'd0,
      LANE_16 = 2'd1,
      LANE_32 = 2'd2,
      LANE_64 = 2'd3
   } lane_sz_e;

   typedef struct packed {
      lane_sz_e             size;
      logic [SHAMT_W-1:0]   shamt;
      logic                 bad;
   } field_dec_t;
endpackage

// File: rtl/lsi_decode.sv
module lsi_decode
   import lsi_pkg::*;
(
   input  logic [FIELD_W-1:0] field,
   output field_dec_t         dec
);
   always_comb begin
      dec       = '0;
      dec.size  = LANE_8;
      if (field[6]) begin
         dec.size  = LANE_64;
         dec.shamt = field[5:0];
      end else if (field[5]) begin
         dec.size  = LANE_32;
         dec.shamt = {1'b0, field[4:0]};
      end else if (field[4]) begin
         dec.size  = LANE_16;
         dec.shamt = {2'b00, field[3:0]};
      end else if (field[3]) begin
         dec.size  = LANE_8;
         dec.shamt = {3'b000, field[2:0]};
      end else begin
         dec.bad   = 1'b1;
      end
   end
endmodule

// File: rtl/lsi_lane_merge.sv
module lsi_lane_merge #(
   parameter  int LW = 8,
   localparam int SW = $clog2(LW)
) (
   input  logic [LW-1:0] src,
   input  logic [LW-1:0] dst,
   input  logic [SW-1:0] shamt,
   output logic [LW-1:0] res
);
   logic [LW-1:0] keep_mask;
   logic [LW-1:0] moved;

   always_comb begin
      keep_mask = {LW{1'b1}} << shamt;
      moved     = src << shamt;
      res       = (dst & ~keep_mask) | (moved & keep_mask);
   end
endmodule

// File: rtl/lsi_size_array.sv
module lsi_size_array #(
   parameter  int VEC_W = 128,
   parameter  int LW    = 8,
   localparam int SW    = $clog2(LW),
   localparam int NL    = VEC_W / LW
) (
   input  logic [VEC_W-1:0] src,
   input  logic [VEC_W-1:0] dst,
   input  logic [SW-1:0]    shamt,
   output logic [VEC_W-1:0] res
);
   generate
      if ((VEC_W % LW) != 0) begin : g_bad_split
         $error("lsi_size_array: VEC_W must be a multiple of LW");
      end
      for (genvar ln = 0; ln < NL; ln++) begin : g_lane
         lsi_lane_merge #(.LW(LW)) u_lane (
            .src   (src[ln*LW +: LW]),
            .dst   (dst[ln*LW +: LW]),
            .shamt (shamt),
            .res   (res[ln*LW +: LW])
         );
      end
   endgenerate
endmodule

// File: rtl/lane_shift_insert.sv
module lane_shift_insert
   import lsi_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [VEC_W-1:0]    src_vec,
   input  logic [VEC_W-1:0]    dst_vec,
   input  logic [FIELD_W-1:0]  imm_field,
   input  logic                wide_sel,
   output logic                out_valid,
   output logic [VEC_W-1:0]    out_vec,
   output logic                out_illegal
);
   localparam int HALF_W = VEC_W / 2;

   generate
      if ((VEC_W % 128) != 0 || VEC_W < 128) begin : g_bad_width
         $error("lane_shift_insert: VEC_W must be a positive multiple of 128");
      end
   endgenerate

   field_dec_t      dec;
   logic [VEC_W-1:0] by_size [NUM_SIZES];
   logic [VEC_W-1:0] picked;
   logic [VEC_W-1:0] formed;
   logic [VEC_W-1:0] next_vec;

   lsi_decode u_dec (
      .field (imm_field),
      .dec   (dec)
   );

   generate
      for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
         localparam int LW = MIN_LANE << k;
         localparam int SW = $clog2(LW);
         lsi_size_array #(.VEC_W(VEC_W), .LW(LW)) u_arr (
            .src   (src_vec),
            .dst   (dst_vec),
            .shamt (dec.shamt[SW-1:0]),
            .res   (by_size[k])
         );
      end
   endgenerate

   always_comb begin
      picked = by_size[dec.size];
      if (wide_sel) formed = picked;
      else          formed = {dst_vec[VEC_W-1:HALF_W], picked[HALF_W-1:0]};
      next_vec = dec.bad ? dst_vec : formed;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_vec     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_vec     <= next_vec;
            out_illegal <= dec.bad;
         end
      end
   end
endmodule

// File: rtl/lane_shift_insert_chk.sv
module lane_shift_insert_chk #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] src_vec,
   input logic [VEC_W-1:0] dst_vec,
   input logic [6:0]       imm_field,
   input logic             wide_sel,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_vec,
   input logic             out_illegal
);
   localparam int HALF_W = VEC_W / 2;

   logic field_void;
   assign field_void = !imm_field[6] && (imm_field[5:3] == 3'b000);

   // R8
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_vec) && $stable(out_illegal)));
   // R7
   void_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && field_void) |=> (out_illegal && out_vec == $past(dst_vec)));
   // R7
   legal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !field_void) |=> !out_illegal);
   // R6
   half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide_sel) |=> out_vec[VEC_W-1:HALF_W] == $past(dst_vec[VEC_W-1:HALF_W]));
   // R5
   zero_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide_sel && imm_field == 7'b1000000) |=> out_vec == $past(src_vec));
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !out_illegal && out_vec == '0));
endmodule

bind lane_shift_insert lane_shift_insert_chk #(.VEC_W(VEC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .src_vec     (src_vec),
   .dst_vec     (dst_vec),
   .imm_field   (imm_field),
   .wide_sel    (wide_sel),
   .out_valid   (out_valid),
   .out_vec     (out_vec),
   .out_illegal (out_illegal)
);

// File: tb/lane_shift_insert_bench.sv
module lane_shift_insert_bench;
   localparam int  VW        = 128;
   localparam time CLK_PER   = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [VW-1:0] src_vec, dst_vec;
   logic [6:0]    imm_field;
   logic          wide_sel;
   logic          out_valid;
   logic [VW-1:0] out_vec;
   logic          out_illegal;

   int total = 0;
   int bad   = 0;

   always #(CLK_PER/2) clk = ~clk;

   lane_shift_insert #(.VEC_W(VW)) u_lane_shift_insert (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_vec(src_vec), .dst_vec(dst_vec), .imm_field(imm_field),
      .wide_sel(wide_sel), .out_valid(out_valid), .out_vec(out_vec),
      .out_illegal(out_illegal)
   );

   function automatic bit field_void(input logic [6:0] f);
      return !f[6] && f[5:3] == 3'b000;
   endfunction

   // Bit-level model built from R1..R7
   function automatic logic [VW-1:0] model(input logic [VW-1:0] s, input logic [VW-1:0] d,
                                           input logic [6:0] f, input logic w);
      logic [VW-1:0] r = d;
      int lw = 8;
      int sh = 0;
      int span;
      if (f[6])      begin lw = 64; sh = int'(f[5:0]); end
      else if (f[5]) begin lw = 32; sh = int'(f[4:0]); end
      else if (f[4]) begin lw = 16; sh = int'(f[3:0]); end
      else if (f[3]) begin lw = 8;  sh = int'(f[2:0]); end
      else return d;
      span = w ? VW : VW/2;
      for (int b = 0; b < span; b += lw)
         for (int j = 0; j < lw; j++)
            if (j >= sh) r[b+j] = s[b+j-sh];
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b", req, act, exp);
      end
   endtask

   // drive at falling edge, sample at the next falling edge (one register)
   task automatic run_op(input string req, input logic [VW-1:0] s, input logic [VW-1:0] d,
                         input logic [6:0] f, input logic w);
      @(negedge clk);
      src_vec = s; dst_vec = d; imm_field = f; wide_sel = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({req, " valid R8"}, out_valid, 1'b1);
      check_bit({req, " illegal R7"}, out_illegal, field_void(f));
      check_vec(req, out_vec, model(s, d, f, w));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; in_valid = 1'b1; src_vec = '1; dst_vec = '1;
      imm_field = 7'h40; wide_sel = 1'b1;
      repeat (3) @(negedge clk);
      check_bit("R9 valid", out_valid, 1'b0);
      check_bit("R9 illegal", out_illegal, 1'b0);
      check_vec("R9 vec", out_vec, '0);
      in_valid = 1'b0; rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_lane64;
      run_op("R1 64 sh5", {4{32'hdeadbeef}}, {4{32'h12345678}}, 7'b1000101, 1'b1);
      run_op("R1 64 sh63", {2{64'h1}}, '1, 7'b1111111, 1'b1);
      check_vec("R1 64 sh63 exact", out_vec, {2{64'hffff_ffff_ffff_ffff}} & ~{2{64'h7fff_ffff_ffff_ffff}} | {2{64'h7fff_ffff_ffff_ffff}});
   endtask

   task automatic t_narrow_lanes;
      run_op("R2 32 sh17", {4{32'hcafe_f00d}}, {4{32'h0f0f_0f0f}}, 7'b0110001, 1'b1);
      run_op("R2 16 sh9",  128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, {8{16'ha5a5}}, 7'b0011001, 1'b1);
      run_op("R2 8 sh3",   128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff, {16{8'h5a}}, 7'b0001011, 1'b1);
   endtask

   task automatic t_no_spill;
      run_op("R3 8 sh7", '1, '0, 7'b0001111, 1'b1);
      check_vec("R3 8 exact", out_vec, {16{8'h80}});
      run_op("R3 16 sh15", '1, '0, 7'b0011111, 1'b1);
      check_vec("R3 16 exact", out_vec, {8{16'h8000}});
   endtask

   task automatic t_keep_low;
      run_op("R4 32 sh4", '0, '1, 7'b0100100, 1'b1);
      check_vec("R4 keep exact", out_vec, {4{32'h0000_000f}});
   endtask

   task automatic t_zero_shift;
      run_op("R5 8 sh0", 128'h1357_9bdf_2468_ace0_1122_3344_5566_7788, '1, 7'b0001000, 1'b1);
      check_vec("R5 copy exact", out_vec, 128'h1357_9bdf_2468_ace0_1122_3344_5566_7788);
      run_op("R5 64 sh0", {4{32'h8badf00d}}, '0, 7'b1000000, 1'b1);
   endtask

   task automatic t_half_form;
      run_op("R6 half 16 sh2", {8{16'hffff}}, 128'hdead_beef_0000_1111_0000_0000_0000_0000, 7'b0010010, 1'b0);
      check_vec("R6 upper exact", {out_vec[VW-1:VW/2], 64'h0}, {64'hdead_beef_0000_1111, 64'h0});
      run_op("R6 half 64 sh0", '1, '0, 7'b1000000, 1'b0);
   endtask

   task automatic t_void;
      run_op("R7 all zero", '1, 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0, 7'b0000000, 1'b1);
      run_op("R7 low bits", '1, 128'h0123_0000_4567_0000_89ab_0000_cdef_0000, 7'b0000111, 1'b1);
      run_op("R7 legal after", '1, '0, 7'b0001001, 1'b1);
   endtask

   task automatic t_hold;
      logic [VW-1:0] kept;
      run_op("R8 setup", {8{16'h1234}}, '0, 7'b0010000, 1'b1);
      kept = out_vec;
      src_vec = '1; dst_vec = '0; imm_field = 7'b0000000;
      repeat (3) @(negedge clk);
      check_bit("R8 idle valid", out_valid, 1'b0);
      check_bit("R8 idle illegal", out_illegal, 1'b0);
      check_vec("R8 idle hold", out_vec, kept);
   endtask

   initial begin
      #(CLK_PER * 100000);
      bad++; total++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_lane64();
      t_narrow_lanes();
      t_no_spill();
      t_keep_low();
      t_zero_shift();
      t_half_form();
      t_void();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule